// File: doc/BRIEF.md
# NRZI Serial Transmitter with Forced-Mark Line Override

This block turns bytes from a one-deep transmit holding register into a serial bit stream. It sends the least significant bit first and advances one bit per bit-clock enable. Between characters it sends idle bits, either continuous ones or a repeating flag pattern. The stream leaves the block as plain NRZ levels or NRZI encoded, as the encoding selector chooses.

A control input, `force_high`, acts as a pseudo transmitter disable. While it is set and NRZI is selected, the line is pinned high. Any character being shifted out is abandoned, and writes to the holding register are thrown away. The NRZI encoder keeps running on idle bits underneath, so when the control drops, the line takes the encoder's current level straight away, even between bit boundaries.

The intended use is to raise `force_high` after an underrun, once the frame check and closing flag are out. An end-of-frame input parks the transmitter in a hold state until a close-done pulse reports that the closing sequence has been sent.

The controller is a four-state machine:
- IDLE sends idle bits.
- SHIFT sends a character.
- HOLD waits for close-done after end of frame.
- PARK is used while the line is forced.

Its transitions are:
- IDLE to SHIFT on a load.
- SHIFT to SHIFT on a back-to-back load.
- SHIFT to IDLE at a character end with nothing to load.
- IDLE to HOLD on `frame_end`.
- HOLD to IDLE on `close_done`.
- Any state to PARK while forced.
- PARK to IDLE on release.

Top module: `nrzi_tx`

## Requirements
- R1: After reset `line_out` is 1 and `buf_empty` is 1; the NRZI level and the NRZ bit register both reset to 1, and the flag pattern phase resets to its first bit.
- R2: A write (`wr_en` high) that is not blocked stores `wr_data` and drives `buf_empty` low in the next cycle. A write in the same cycle as a load keeps the new byte, so `buf_empty` stays 0.
- R3: Each `bit_en` pulse puts the next bit on the line one clock later. Characters go out least significant bit first. A byte waiting in the register is loaded at the bit after the last bit of the previous character, with no gap, and the load empties the register.
- R4: When `enc_mode` is any value other than 2'b10 (NRZ), `line_out` equals the current data bit.
- R5: When `enc_mode` is 2'b10 (NRZI), the line level toggles on each 0 bit and holds on each 1 bit. Without a `bit_en` pulse the line does not change.
- R6: Idle bits are all ones when `idle_flag` is 0. When `idle_flag` is 1, idle bits are the flag byte 8'h7E sent least significant bit first (0,1,1,1,1,1,1,0). The flag phase advances only on idle bits.
- R7: With NRZI selected and `force_high` set, `line_out` is 1 in that same cycle, for mark and flag idle alike.
- R8: Raising `force_high` in NRZI mode abandons the character in flight. None of its remaining bits reach the line after release.
- R9: With NRZI selected and `force_high` set, writes are discarded, `buf_empty` does not change, and no byte is loaded.
- R10: The NRZI encoder keeps advancing on idle bits during the override. When `force_high` falls, `line_out` takes the encoder level in that same cycle.
- R11: With `enc_mode` not 2'b10, `force_high` has no effect: writes are kept, characters are not cut, and the line follows the data.
- R12: A `frame_end` pulse in IDLE enters HOLD. HOLD loads nothing and sends idle bits until a `close_done` pulse returns to IDLE. A `frame_end` pulse outside IDLE is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bit_en | input | 1 | Bit-clock enable, one pulse per line bit |
| wr_en | input | 1 | Transmit holding register write strobe |
| wr_data | input | 8 | Byte to transmit |
| force_high | input | 1 | Pseudo disable: pin line high (NRZI only) |
| enc_mode | input | 2 | Encoding select, 2'b10 = NRZI, else NRZ |
| idle_flag | input | 1 | 1 = flag idle, 0 = mark idle |
| frame_end | input | 1 | Underrun / end-of-frame pulse |
| close_done | input | 1 | Frame check and closing flag sent pulse |
| line_out | output | 1 | Serial line |
| buf_empty | output | 1 | Holding register empty |

## Verification
Two collisions are provoked on purpose by driving both events on the same clock edge. In the first, a byte is written in the cycle `force_high` rises under NRZI. The write must be lost, which is judged by `buf_empty` staying high and by no character following release. In the second, a write coincides with the load of the previous byte. That case is judged by the old byte's first bit reaching the line while `buf_empty` stays low, and by the new byte following back-to-back.

// File: rtl/nrzi_tx_pkg.sv
package nrzi_tx_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SHIFT = 2'd1,
        ST_HOLD  = 2'd2,
        ST_PARK  = 2'd3
    } tx_state_e;

    localparam logic [1:0] ENC_NRZI = 2'b10;
endpackage

// File: rtl/nrzi_tx_holdreg.sv
module nrzi_tx_holdreg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_accept,
    input  logic [W-1:0] wr_data,
    input  logic         take,
    output logic [W-1:0] data_o,
    output logic         full_o
);
    // A write in the same cycle as a take wins: the new byte stays held.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_o <= '0;
            full_o <= 1'b0;
        end else if (wr_accept) begin
            data_o <= wr_data;
            full_o <= 1'b1;
        end else if (take) begin
            full_o <= 1'b0;
        end
    end
endmodule

// File: rtl/nrzi_tx_idlegen.sv
module nrzi_tx_idlegen #(
    parameter int              PAT_W   = 8,
    parameter logic [PAT_W-1:0] PATTERN = 8'h7E
) (
    input  logic clk,
    input  logic rst_n,
    input  logic advance,
    input  logic flag_mode,
    output logic bit_o
);
    localparam int IW = (PAT_W > 1) ? $clog2(PAT_W) : 1;
    localparam logic [IW-1:0] LAST = IW'(PAT_W - 1);

    logic [IW-1:0] idx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx <= '0;
        end else if (advance) begin
            idx <= (idx == LAST) ? '0 : idx + 1'b1;
        end
    end

    assign bit_o = flag_mode ? PATTERN[idx] : 1'b1;
endmodule

// File: rtl/nrzi_tx_shifter.sv
module nrzi_tx_shifter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_data,
    input  logic         shift,
    output logic         bit_o,
    output logic         last_o
);
    localparam int CW = (W > 2) ? $clog2(W) : 1;
    localparam logic [CW-1:0] FIRST_LEFT = CW'(W - 1);

    logic [W-1:0]  sreg;
    logic [CW-1:0] left;

    // Bit 0 of a loaded byte goes out at the load; the rest wait here.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sreg <= '0;
            left <= '0;
        end else if (load) begin
            sreg <= load_data >> 1;
            left <= FIRST_LEFT;
        end else if (shift) begin
            sreg <= sreg >> 1;
            left <= left - 1'b1;
        end
    end

    assign bit_o  = sreg[0];
    assign last_o = (left == '0);
endmodule

// File: rtl/nrzi_tx_encoder.sv
module nrzi_tx_encoder (
    input  logic clk,
    input  logic rst_n,
    input  logic adv,
    input  logic bit_i,
    output logic level_o,
    output logic raw_o
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            level_o <= 1'b1;
            raw_o   <= 1'b1;
        end else if (adv) begin
            level_o <= level_o ^ ~bit_i;
            raw_o   <= bit_i;
        end
    end
endmodule

// File: rtl/nrzi_tx.sv
module nrzi_tx
    import nrzi_tx_pkg::*;
#(
    parameter int              DATA_W   = 8,
    parameter logic [DATA_W-1:0] IDLE_PAT = 8'h7E
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_en,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              force_high,
    input  logic [1:0]        enc_mode,
    input  logic              idle_flag,
    input  logic              frame_end,
    input  logic              close_done,
    output logic              line_out,
    output logic              buf_empty
);
    tx_state_e state, state_nx;

    logic              forced;
    logic              buf_full;
    logic [DATA_W-1:0] buf_data;
    logic              sh_bit, sh_last;
    logic              idle_bit;
    logic              boundary, can_load, load, in_char, shift, idle_adv;
    logic              next_bit;
    logic              enc_level, enc_raw;

    assign forced   = force_high && (enc_mode == ENC_NRZI);
    assign boundary = (state != ST_SHIFT) || sh_last;
    assign can_load = buf_full && !forced &&
                      ((state == ST_IDLE) || (state == ST_SHIFT));
    assign load     = bit_en && boundary && can_load;
    assign in_char  = (state == ST_SHIFT) && !sh_last && !forced;
    assign shift    = bit_en && in_char;
    assign idle_adv = bit_en && !load && !in_char;

    always_comb begin
        if (load)         next_bit = buf_data[0];
        else if (in_char) next_bit = sh_bit;
        else              next_bit = idle_bit;
    end

    nrzi_tx_holdreg #(.W(DATA_W)) u_hold (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_accept (wr_en && !forced),
        .wr_data   (wr_data),
        .take      (load),
        .data_o    (buf_data),
        .full_o    (buf_full)
    );

    nrzi_tx_shifter #(.W(DATA_W)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .load_data (buf_data),
        .shift     (shift),
        .bit_o     (sh_bit),
        .last_o    (sh_last)
    );

    nrzi_tx_idlegen #(.PAT_W(DATA_W), .PATTERN(IDLE_PAT)) u_idle (
        .clk       (clk),
        .rst_n     (rst_n),
        .advance   (idle_adv),
        .flag_mode (idle_flag),
        .bit_o     (idle_bit)
    );

    nrzi_tx_encoder u_enc (
        .clk     (clk),
        .rst_n   (rst_n),
        .adv     (bit_en),
        .bit_i   (next_bit),
        .level_o (enc_level),
        .raw_o   (enc_raw)
    );

    always_comb begin
        state_nx = state;
        if (forced) begin
            state_nx = ST_PARK;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (load)           state_nx = ST_SHIFT;
                    else if (frame_end) state_nx = ST_HOLD;
                end
                ST_SHIFT: begin
                    if (bit_en && sh_last && !load) state_nx = ST_IDLE;
                end
                ST_HOLD: begin
                    if (close_done) state_nx = ST_IDLE;
                end
                ST_PARK: state_nx = ST_IDLE;
                default: state_nx = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        if (forced)                     line_out = 1'b1;
        else if (enc_mode == ENC_NRZI)  line_out = enc_level;
        else                            line_out = enc_raw;
        buf_empty = !buf_full;
    end
endmodule

// File: rtl/nrzi_tx_chk.sv
module nrzi_tx_chk
    import nrzi_tx_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       bit_en,
    input logic       wr_en,
    input logic       force_high,
    input logic [1:0] enc_mode,
    input logic       close_done,
    input logic       line_out,
    input logic       buf_empty,
    input tx_state_e  state
);
    a_r7_forced_line_high: assert property (@(posedge clk) disable iff (!rst_n)
        (force_high && enc_mode == ENC_NRZI) |-> line_out);

    a_r9_forced_write_dropped: assert property (@(posedge clk) disable iff (!rst_n)
        (force_high && enc_mode == ENC_NRZI && wr_en && buf_empty) |=> buf_empty);

    a_r2_write_held: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !(force_high && enc_mode == ENC_NRZI)) |=> !buf_empty);

    a_r5_line_steady: assert property (@(posedge clk) disable iff (!rst_n)
        (!bit_en && !force_high && enc_mode == ENC_NRZI) ##1
        (!force_high && enc_mode == ENC_NRZI) |-> $stable(line_out));

    a_r12_hold_keeps_byte: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HOLD && !close_done && !force_high && !buf_empty) |=> !buf_empty);

    a_r8_forced_leaves_shift: assert property (@(posedge clk) disable iff (!rst_n)
        (force_high && enc_mode == ENC_NRZI) |=> state != ST_SHIFT);
endmodule

bind nrzi_tx nrzi_tx_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bit_en     (bit_en),
    .wr_en      (wr_en),
    .force_high (force_high),
    .enc_mode   (enc_mode),
    .close_done (close_done),
    .line_out   (line_out),
    .buf_empty  (buf_empty),
    .state      (state)
);

// File: tb/nrzi_tx_tb.sv
module nrzi_tx_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bit_en = 1'b0, wr_en = 1'b0, force_high = 1'b0;
    logic [7:0] wr_data = '0;
    logic [1:0] enc_mode = 2'b00;
    logic       idle_flag = 1'b0, frame_end = 1'b0, close_done = 1'b0;
    logic       line_out, buf_empty;
    int         checks = 0, errors = 0;
    logic       lvl;

    always #10 clk = ~clk;

    nrzi_tx u_dut (
        .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .wr_en(wr_en),
        .wr_data(wr_data), .force_high(force_high), .enc_mode(enc_mode),
        .idle_flag(idle_flag), .frame_end(frame_end), .close_done(close_done),
        .line_out(line_out), .buf_empty(buf_empty)
    );

    task automatic check(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    task automatic do_reset(input logic [1:0] mode, input logic flag);
        @(negedge clk);
        rst_n = 1'b0; bit_en = 0; wr_en = 0; force_high = 0;
        frame_end = 0; close_done = 0; enc_mode = mode; idle_flag = flag;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        lvl = 1'b1;
    endtask

    task automatic pulse_bit();
        bit_en = 1'b1;
        @(negedge clk);
        bit_en = 1'b0;
    endtask

    task automatic write_byte(input logic [7:0] d);
        wr_en = 1'b1; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic t_reset();
        do_reset(2'b10, 1'b0);
        check("R1 line after reset", line_out, 1'b1);
        check("R1 empty after reset", buf_empty, 1'b1);
    endtask

    task automatic t_nrz_byte();
        logic [7:0] b = 8'hA5;
        do_reset(2'b00, 1'b0);
        write_byte(b);
        check("R2 write clears empty", buf_empty, 1'b0);
        for (int i = 0; i < 8; i++) begin
            pulse_bit();
            check("R3/R4 NRZ bit", line_out, b[i]);
            if (i == 0) check("R3 load empties", buf_empty, 1'b1);
        end
        pulse_bit();
        check("R6 mark idle", line_out, 1'b1);
    endtask

    task automatic t_nrzi_byte();
        logic [7:0] b = 8'h3C;
        do_reset(2'b10, 1'b0);
        write_byte(b);
        for (int i = 0; i < 8; i++) begin
            pulse_bit();
            if (!b[i]) lvl = ~lvl;
            check("R5 NRZI level", line_out, lvl);
        end
        repeat (3) @(negedge clk);
        check("R5 no change without bit_en", line_out, lvl);
    endtask

    task automatic t_flag_idle();
        logic [7:0] f = 8'h7E;
        do_reset(2'b00, 1'b1);
        for (int i = 0; i < 8; i++) begin
            pulse_bit();
            check("R6 flag idle bit", line_out, f[i]);
        end
    endtask

    task automatic t_chop();
        do_reset(2'b10, 1'b0);
        write_byte(8'h00);
        repeat (3) pulse_bit();
        check("R5 level before force", line_out, 1'b0);
        force_high = 1'b1;
        @(negedge clk);
        check("R7 forced high", line_out, 1'b1);
        write_byte(8'h55);
        check("R9 forced write dropped", buf_empty, 1'b1);
        repeat (5) pulse_bit();
        check("R7 forced high on idle", line_out, 1'b1);
        force_high = 1'b0;
        #1;
        check("R10 release takes level", line_out, 1'b0);
        @(negedge clk);
        repeat (5) pulse_bit();
        check("R8 chopped bits absent", line_out, 1'b0);
        check("R9 nothing loaded", buf_empty, 1'b1);
    endtask

    task automatic t_encoder_runs();
        do_reset(2'b10, 1'b1);
        force_high = 1'b1;
        @(negedge clk);
        repeat (3) pulse_bit();
        check("R7 forced during flag idle", line_out, 1'b1);
        force_high = 1'b0;
        @(negedge clk);
        check("R10 encoder advanced under force", line_out, 1'b0);
    endtask

    task automatic t_nrz_force_ignored();
        logic [7:0] b = 8'h0F;
        do_reset(2'b00, 1'b0);
        force_high = 1'b1;
        write_byte(b);
        check("R11 write kept in NRZ", buf_empty, 1'b0);
        for (int i = 0; i < 8; i++) begin
            pulse_bit();
            check("R11 NRZ data under force", line_out, b[i]);
        end
        force_high = 1'b0;
    endtask

    task automatic t_hold();
        do_reset(2'b00, 1'b0);
        frame_end = 1'b1;
        @(negedge clk);
        frame_end = 1'b0;
        write_byte(8'h00);
        repeat (3) pulse_bit();
        check("R12 hold sends idle", line_out, 1'b1);
        check("R12 hold keeps byte", buf_empty, 1'b0);
        close_done = 1'b1;
        @(negedge clk);
        close_done = 1'b0;
        pulse_bit();
        check("R12 load after close", line_out, 1'b0);
        check("R12 byte taken", buf_empty, 1'b1);
    endtask

    task automatic t_write_on_load();
        logic [7:0] a = 8'h01;
        logic [7:0] b = 8'h80;
        do_reset(2'b00, 1'b0);
        write_byte(a);
        bit_en = 1'b1; wr_en = 1'b1; wr_data = b;
        @(negedge clk);
        bit_en = 1'b0; wr_en = 1'b0;
        check("R2 old byte first bit", line_out, a[0]);
        check("R2 new byte held", buf_empty, 1'b0);
        for (int i = 1; i < 8; i++) begin
            pulse_bit();
            check("R3 first byte bit", line_out, a[i]);
        end
        for (int i = 0; i < 8; i++) begin
            pulse_bit();
            check("R3 back-to-back bit", line_out, b[i]);
            if (i == 0) check("R3 second load empties", buf_empty, 1'b1);
        end
    endtask

    task automatic t_force_with_write();
        do_reset(2'b10, 1'b0);
        force_high = 1'b1; wr_en = 1'b1; wr_data = 8'h00;
        @(negedge clk);
        wr_en = 1'b0;
        check("R9 same-cycle write dropped", buf_empty, 1'b1);
        force_high = 1'b0;
        @(negedge clk);
        repeat (4) pulse_bit();
        check("R9 no character after release", line_out, 1'b1);
    endtask

    initial begin
        t_reset();
        t_nrz_byte();
        t_nrzi_byte();
        t_flag_idle();
        t_chop();
        t_encoder_runs();
        t_nrz_force_ignored();
        t_hold();
        t_write_on_load();
        t_force_with_write();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule